// File: doc/BRIEF.md
# Error Exception Return-Address Capture

This block keeps the restart address that a processor core saves when it takes an error-class exception: a cache error, a cold reset, a soft reset or a non-maskable interrupt. Each cycle, the core's exception logic presents the following:

- an exception strobe and a class code;
- the virtual address of the faulting instruction;
- the address of the instruction before it;
- flags saying whether the faulting instruction sits in a branch delay slot or directly follows an extend prefix;
- the ISA mode currently executing (32-bit or 16-bit compressed).

The block decides whether to capture and which of the two addresses to keep. When compressed-ISA support is enabled, it tags bit 0 of the stored value with the active ISA mode.

A successful capture sets an internal error-level bit on the next cycle. While that bit is set, every later hardware capture is suppressed, so the restart address of the first error survives any nested exception. A clear input models the handler's return and drops the bit. Software reads the stored value at any time and may overwrite it through a one-cycle write strobe. If a hardware capture and a software write land in the same cycle, the hardware capture wins.

The compressed-ISA enable comes from an external pin. The block samples it on the first clock edge after reset and holds it from then on. That held value selects the register format.

Top module: `err_ret_addr`

## Requirements
- R1: Only class codes 4 (cache error), 5 (cold reset), 6 (soft reset) and 7 (non-maskable interrupt) cause a capture. Codes 0 to 3 leave `rd_data` unchanged and do not raise `capture_o`.
- R2: In the ordinary case (no delay slot, no extend prefix), a capture stores `fault_addr` with bit 0 replaced by the mode tag.
- R3: When `in_delay_slot` is 1, a capture stores `prev_addr` instead, in either ISA mode and whether or not compressed-ISA support is enabled.
- R4: When compressed-ISA support is enabled and `isa16_mode` is 1, `after_extend` = 1 selects `prev_addr`. In 32-bit mode, or with support disabled, `after_extend` has no effect.
- R5: With compressed-ISA support enabled, a capture writes bit 0 as `isa16_mode` (1 = 16-bit). With support disabled, bit 0 is always stored as 0.
- R6: While `erl_o` is 1, exceptions of any class leave `rd_data` unchanged and keep `capture_o` low.
- R7: `capture_o` is high in the same cycle as a qualifying exception, and `erl_o` is 1 from the next cycle. When no capture occurs, `erl_clr` drops `erl_o` to 0 on the next cycle.
- R8: The compressed-ISA enable is taken from `cisa_pin` at the first clock edge after reset. Later changes of the pin have no effect until the next reset.
- R9: After reset, `rd_data` is 0 and `erl_o` is 0. A software write stores `sw_wr_data`, with bit 0 forced to 0 when compressed-ISA support is disabled, and the value appears on `rd_data` the next cycle. Writes are accepted even while `erl_o` is 1.
- R10: When a hardware capture and a software write happen in the same cycle, the captured address is stored and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid | input | 1 | Exception strobe |
| exc_class | input | 3 | Exception class code |
| fault_addr | input | ADDR_W | Virtual address of the faulting instruction |
| prev_addr | input | ADDR_W | Address of the preceding jump, branch or extend prefix |
| in_delay_slot | input | 1 | Faulting instruction is in a branch/jump delay slot |
| after_extend | input | 1 | Faulting instruction directly follows an extend prefix |
| isa16_mode | input | 1 | Current ISA mode, 1 = 16-bit compressed |
| cisa_pin | input | 1 | Compressed-ISA enable pin, sampled after reset |
| erl_clr | input | 1 | Clears the error-level bit (handler return) |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | ADDR_W | Software write data |
| rd_data | output | ADDR_W | Stored restart address |
| erl_o | output | 1 | Error-level bit |
| capture_o | output | 1 | A hardware capture happens this cycle |

## Verification
Embedded assertions check the following on every cycle:

- non-error classes and a set error level never disturb the stored value;
- a capture always sets the error level and stores the hardware value over a concurrent write;
- a delay-slot capture stores the preceding address;
- bit 0 stays 0 whenever compressed-ISA support is disabled;
- the sampled enable never moves after its first edge.

Only the bench's scenarios can show that the full selection table is right for each class, flag and mode combination, under both pin settings. The same applies to three other behaviours: the pin is ignored after sampling, software writes are masked correctly, and the error level is released by the clear input.

// File: rtl/erac_pkg.sv
package erac_pkg;

  localparam int CLASS_W = 3;

  typedef enum logic [CLASS_W-1:0] {
    EXC_GENERIC0 = 3'd0,
    EXC_GENERIC1 = 3'd1,
    EXC_GENERIC2 = 3'd2,
    EXC_GENERIC3 = 3'd3,
    EXC_CACHE_ERR = 3'd4,
    EXC_COLD_RST  = 3'd5,
    EXC_SOFT_RST  = 3'd6,
    EXC_NMI       = 3'd7
  } exc_class_e;

  // True for the four classes that use the error return register.
  function automatic logic is_error_class(input logic [CLASS_W-1:0] code);
    exc_class_e c;
    c = exc_class_e'(code);
    case (c)
      EXC_CACHE_ERR, EXC_COLD_RST, EXC_SOFT_RST, EXC_NMI: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Decides whether the preceding instruction's address is the restart point.
  function automatic logic restart_on_prev(input logic delay_slot,
                                           input logic follows_ext,
                                           input logic mode16,
                                           input logic cisa_en);
    logic ext_counts;
    ext_counts = cisa_en & mode16 & follows_ext;
    return delay_slot | ext_counts;
  endfunction

  // Mode tag written into bit 0.
  function automatic logic mode_tag(input logic mode16, input logic cisa_en);
    return cisa_en & mode16;
  endfunction

endpackage

// File: rtl/erac_mode_latch.sv
module erac_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic en_o,
  output logic locked_o
);
  logic locked_q;
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      en_q     <= 1'b0;
    end else if (!locked_q) begin
      locked_q <= 1'b1;
      en_q     <= pin_i;
    end
  end

  // Before the first edge the live pin is used, so the value seen at the
  // sampling edge and the value held afterwards agree.
  assign en_o     = locked_q ? en_q : pin_i;
  assign locked_o = locked_q;

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> (locked_q && $stable(en_q)));

endmodule

// File: rtl/erac_addr_sel.sv
module erac_addr_sel #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] fault_i,
  input  logic [ADDR_W-1:0] prev_i,
  input  logic              delay_slot_i,
  input  logic              after_ext_i,
  input  logic              mode16_i,
  input  logic              cisa_en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              use_prev_o
);
  import erac_pkg::*;

  logic [ADDR_W-1:0] base;
  logic              tag;

  always_comb begin
    use_prev_o = restart_on_prev(delay_slot_i, after_ext_i, mode16_i, cisa_en_i);
    base       = use_prev_o ? prev_i : fault_i;
    tag        = mode_tag(mode16_i, cisa_en_i);
    addr_o     = {base[ADDR_W-1:1], tag};
  end

endmodule

// File: rtl/erac_capture_reg.sv
module erac_capture_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_fire_i,
  input  logic [ADDR_W-1:0] hw_val_i,
  input  logic              sw_we_i,
  input  logic [ADDR_W-1:0] sw_val_i,
  input  logic              clr_i,
  output logic [ADDR_W-1:0] val_o,
  output logic              erl_o
);
  logic [ADDR_W-1:0] val_q;
  logic              erl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (hw_fire_i) begin
      val_q <= hw_val_i;
    end else if (sw_we_i) begin
      val_q <= sw_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erl_q <= 1'b0;
    end else if (hw_fire_i) begin
      erl_q <= 1'b1;
    end else if (clr_i) begin
      erl_q <= 1'b0;
    end
  end

  assign val_o = val_q;
  assign erl_o = erl_q;

  // R6
  frozen_under_erl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erl_q && !sw_we_i) |=> $stable(val_q));

  // R6
  no_fire_under_erl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erl_q |-> !hw_fire_i);

  // R7
  erl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_fire_i |=> erl_q);

  // R7
  erl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hw_fire_i) |=> !erl_q);

  // R10
  hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_fire_i |=> (val_q == $past(hw_val_i)));

endmodule

// File: rtl/err_ret_addr.sv
module err_ret_addr #(
  parameter int ADDR_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         exc_valid,
  input  logic [erac_pkg::CLASS_W-1:0] exc_class,
  input  logic [ADDR_W-1:0]            fault_addr,
  input  logic [ADDR_W-1:0]            prev_addr,
  input  logic                         in_delay_slot,
  input  logic                         after_extend,
  input  logic                         isa16_mode,
  input  logic                         cisa_pin,
  input  logic                         erl_clr,
  input  logic                         sw_wr_en,
  input  logic [ADDR_W-1:0]            sw_wr_data,
  output logic [ADDR_W-1:0]            rd_data,
  output logic                         erl_o,
  output logic                         capture_o
);
  import erac_pkg::*;

  logic              cisa_en;
  logic              mode_locked;
  logic [ADDR_W-1:0] hw_addr;
  logic              use_prev;
  logic              class_hit;
  logic              cap_fire;
  logic [ADDR_W-1:0] sw_masked;
  logic              erl_now;

  erac_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (cisa_pin),
    .en_o     (cisa_en),
    .locked_o (mode_locked)
  );

  erac_addr_sel #(.ADDR_W(ADDR_W)) u_sel (
    .fault_i      (fault_addr),
    .prev_i       (prev_addr),
    .delay_slot_i (in_delay_slot),
    .after_ext_i  (after_extend),
    .mode16_i     (isa16_mode),
    .cisa_en_i    (cisa_en),
    .addr_o       (hw_addr),
    .use_prev_o   (use_prev)
  );

  assign class_hit = is_error_class(exc_class);
  assign cap_fire  = exc_valid & class_hit & ~erl_now;
  assign sw_masked = {sw_wr_data[ADDR_W-1:1], sw_wr_data[0] & cisa_en};

  erac_capture_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_fire_i (cap_fire),
    .hw_val_i  (hw_addr),
    .sw_we_i   (sw_wr_en),
    .sw_val_i  (sw_masked),
    .clr_i     (erl_clr),
    .val_o     (rd_data),
    .erl_o     (erl_now)
  );

  assign erl_o     = erl_now;
  assign capture_o = cap_fire;

  // R1
  non_error_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !class_hit && !sw_wr_en) |=> $stable(rd_data));

  // R3
  delay_slot_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && in_delay_slot) |=> (rd_data[ADDR_W-1:1] == $past(prev_addr[ADDR_W-1:1])));

  // R4
  ext_ignored_32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && !in_delay_slot && !(cisa_en && isa16_mode))
      |=> (rd_data[ADDR_W-1:1] == $past(fault_addr[ADDR_W-1:1])));

  // R5
  tag_zero_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_locked && !cisa_en) |-> !rd_data[0]);

  // R4
  sel_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && cisa_en && isa16_mode && after_extend) |-> use_prev);

endmodule

// File: tb/err_ret_addr_tb_top.sv
`timescale 1ns/1ps
module err_ret_addr_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          exc_valid = 1'b0;
  logic [2:0]    exc_class = '0;
  logic [AW-1:0] fault_addr = '0;
  logic [AW-1:0] prev_addr = '0;
  logic          in_delay_slot = 1'b0;
  logic          after_extend = 1'b0;
  logic          isa16_mode = 1'b0;
  logic          cisa_pin = 1'b0;
  logic          erl_clr = 1'b0;
  logic          sw_wr_en = 1'b0;
  logic [AW-1:0] sw_wr_data = '0;
  logic [AW-1:0] rd_data;
  logic          erl_o;
  logic          capture_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  err_ret_addr #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_class(exc_class),
    .fault_addr(fault_addr), .prev_addr(prev_addr), .in_delay_slot(in_delay_slot),
    .after_extend(after_extend), .isa16_mode(isa16_mode), .cisa_pin(cisa_pin),
    .erl_clr(erl_clr), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .rd_data(rd_data), .erl_o(erl_o), .capture_o(capture_o)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Restart address worked out from the requirement text.
  function automatic logic [AW-1:0] model(input logic [AW-1:0] fa, input logic [AW-1:0] pa,
                                         input bit ds, input bit ext, input bit m16, input bit en);
    logic [AW-1:0] r;
    if (ds) r = pa;
    else if (en && m16 && ext) r = pa;
    else r = fa;
    r[0] = en && m16;
    return r;
  endfunction

  task automatic do_reset(input bit pin);
    @(negedge clk);
    rst_n = 1'b0;
    cisa_pin = pin;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic clear_erl();
    erl_clr = 1'b1;
    @(negedge clk);
    erl_clr = 1'b0;
  endtask

  task automatic sweep(input bit en);
    logic [AW-1:0] held;
    logic [AW-1:0] exp;
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 8; k++) begin
        bit ds, ext, m16;
        ds = k[0]; ext = k[1]; m16 = k[2];
        held = rd_data;
        fault_addr = 32'h4000_0000 + (c * 32'h100) + (k * 4) + k[0];
        prev_addr  = fault_addr - 32'd2 - k;
        in_delay_slot = ds; after_extend = ext; isa16_mode = m16;
        exc_class = c[2:0]; exc_valid = 1'b1;
        #1;
        check((c >= 4) ? "R7 capture_o" : "R1 capture_o", {31'd0, capture_o}, {31'd0, c >= 4});
        exp = (c >= 4) ? model(fault_addr, prev_addr, ds, ext, m16, en) : held;
        @(negedge clk);
        exc_valid = 1'b0;
        if (c < 4) check("R1 unchanged", rd_data, exp);
        else if (ds) check("R3 delay slot", rd_data, exp);
        else if (ext) check("R4 extend", rd_data, exp);
        else check("R2 R5 plain", rd_data, exp);
        check("R7 erl set", {31'd0, erl_o}, {31'd0, c >= 4});
        if (c >= 4) begin
          // R6: a second error while frozen must not capture
          held = rd_data;
          fault_addr = ~fault_addr; prev_addr = ~prev_addr; exc_valid = 1'b1;
          #1;
          check("R6 no capture", {31'd0, capture_o}, 32'd0);
          @(negedge clk);
          exc_valid = 1'b0;
          check("R6 frozen", rd_data, held);
          clear_erl();
          check("R7 erl cleared", {31'd0, erl_o}, 32'd0);
        end
      end
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Phase 1: compressed ISA disabled
    do_reset(1'b0);
    check("R9 reset value", rd_data, '0);
    check("R9 reset erl", {31'd0, erl_o}, 32'd0);
    sweep(1'b0);
    // R9: software write with bit 0 masked
    sw_wr_data = 32'hDEAD_BEEF; sw_wr_en = 1'b1;
    @(negedge clk); sw_wr_en = 1'b0;
    check("R9 write masked", rd_data, 32'hDEAD_BEEE);

    // Phase 2: enabled
    do_reset(1'b1);
    check("R9 reset value", rd_data, '0);
    cisa_pin = 1'b0; // R8: pin change after sampling must be ignored
    sweep(1'b1);
    sw_wr_data = 32'h1234_5677; sw_wr_en = 1'b1;
    @(negedge clk); sw_wr_en = 1'b0;
    check("R9 write", rd_data, 32'h1234_5677);

    // R10: capture and write together
    fault_addr = 32'h0000_8880; prev_addr = 32'h0000_7770;
    in_delay_slot = 1'b0; after_extend = 1'b0; isa16_mode = 1'b1;
    exc_class = 3'd7; exc_valid = 1'b1;
    sw_wr_en = 1'b1; sw_wr_data = 32'hFFFF_0000;
    @(negedge clk);
    exc_valid = 1'b0; sw_wr_en = 1'b0;
    check("R10 hw wins", rd_data, 32'h0000_8881);
    check("R8 pin held", {31'd0, rd_data[0]}, 32'd1);

    // R9: software write accepted while erl is set
    sw_wr_data = 32'hCAFE_0002; sw_wr_en = 1'b1;
    @(negedge clk); sw_wr_en = 1'b0;
    check("R9 write under erl", rd_data, 32'hCAFE_0002);
    check("R7 erl still set", {31'd0, erl_o}, 32'd1);
    clear_erl();
    check("R7 erl cleared", {31'd0, erl_o}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule